// File: doc/BRIEF.md
# Keyboard Controller Emulation Trap

This block lets host software stand in for a legacy keyboard controller. It watches a snoop feed of I/O write cycles. While emulation is switched on, a write to the data port (60h) or the command port (64h) is trapped. The trap latches the byte that was written, records which of the two ports it went to, and raises an emulation interrupt so that the emulation software can run.

Software reaches two 32-bit registers through a plain read/write register bus. The control register sits at offset 100h and holds three bits: the enable, the interrupt flag and a character-pending request. The capture register sits at offset 104h and holds the last byte. When character-pending is set, the interrupt is raised on any cycle in which the output-full input is low. This lets software ask to be called back once the output buffer has drained.

Top module: `kbd_emu_trap`

## Requirements
- R1: After reset both registers read as zero, and `irq` and `cmd_port` are 0.
- R2: Offset 100h reads {29'b0, pend, intr, enable} at bits 2, 1 and 0. A bus write stores bits 0 and 2, and bit 1 follows R9. All other bits read 0.
- R3: Offset 104h reads the captured byte in bits 7:0 and zeros above it. A bus write there loads bits 7:0 and has no effect on the interrupt flag, the enable bit or `cmd_port`. Any other offset reads 0.
- R4: An I/O write to 60h or 64h while enable is 1 loads its byte into the capture register at that clock edge.
- R5: Such a trapped write sets the interrupt flag at the same edge.
- R6: `cmd_port` becomes 1 on a trapped write to 64h and 0 on a trapped write to 60h. It holds its value at all other times.
- R7: I/O writes while enable is 0, and writes to any port other than 60h or 64h, change neither the capture register, the interrupt flag nor `cmd_port`.
- R8: While pend is 1, any edge at which `out_full` is 0 sets the interrupt flag.
- R9: A bus write of 0 to bit 1 of offset 100h clears the interrupt flag. A set condition at the same edge (R5, R8) takes priority.
- R10: `irq` is a register equal to interrupt flag AND enable. It rises at the same edge that sets the flag, and goes low when enable is cleared.
- R11: When a trapped I/O write and a bus write to 104h fall on the same edge, the trapped byte is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | 1 = write, qualified by `bus_sel` |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| io_wr | input | 1 | Snooped I/O write cycle valid |
| io_port | input | 16 | Snooped I/O port address |
| io_wdata | input | 8 | Snooped I/O write byte |
| out_full | input | 1 | Emulated output buffer full flag |
| irq | output | 1 | Emulation interrupt request |
| cmd_port | output | 1 | Last trapped write went to 64h |

## Verification
The bench aims at the edges where two causes meet. These are a trapped write together with a bus write to the capture register, which a design with the wrong priority would store as the bus byte. They also include a software clear on the same edge as a trap, which would lose the interrupt if the clear won. Writes to a neighbouring port such as 61h, or writes with emulation off, are checked for leaving the byte and the flag alone, since a loose decode would overwrite the byte. Character-pending is tested with `out_full` held high and then dropped, which catches an interrupt that fires early or never. Clearing enable with the flag still set must silence `irq`.

// File: rtl/kbd_emu_pkg.sv
package kbd_emu_pkg;
  localparam int REG_W  = 32;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 12;
  localparam int PORT_W = 16;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_INTR_BIT = 1;
  localparam int CTRL_PEND_BIT = 2;

  typedef struct packed {
    logic pend;
    logic intr;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/kbd_rst_sync.sv
module kbd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/kbd_io_decode.sv
module kbd_io_decode #(
  parameter int                 PORT_W    = 16,
  parameter logic [PORT_W-1:0]  PORT_DATA = 16'h0060,
  parameter logic [PORT_W-1:0]  PORT_CMD  = 16'h0064
) (
  input  logic              io_wr,
  input  logic [PORT_W-1:0] io_port,
  input  logic              emu_en,
  output logic              trap,
  output logic              trap_cmd
);
  logic hit_data;
  logic hit_cmd;

  always_comb begin
    hit_data = (io_port == PORT_DATA);
    hit_cmd  = (io_port == PORT_CMD);
    trap     = io_wr && emu_en && (hit_data || hit_cmd);
    trap_cmd = hit_cmd;
  end
endmodule

// File: rtl/kbd_ctrl_reg.sv
module kbd_ctrl_reg
  import kbd_emu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_ctrl,
  input  ctrl_t wr_val,
  input  logic  trap,
  input  logic  out_full,
  output ctrl_t ctrl_q,
  output logic  irq
);
  ctrl_t ctrl_d;
  logic  set_intr;
  logic  ctrl_ce;
  logic  irq_d;

  always_comb begin
    set_intr = trap || (ctrl_q.pend && !out_full);
    ctrl_ce  = wr_ctrl || set_intr;
    ctrl_d   = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.en   = wr_val.en;
      ctrl_d.pend = wr_val.pend;
      ctrl_d.intr = wr_val.intr;
    end
    if (set_intr) ctrl_d.intr = 1'b1;
    irq_d = ctrl_d.intr && ctrl_d.en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (ctrl_ce) ctrl_q <= ctrl_d;
      irq <= irq_d;
    end
  end

  AST_TRAP_SETS_INTR: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> ctrl_q.intr); // R5
  AST_PEND_SETS_INTR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.pend && !out_full) |=> ctrl_q.intr); // R8
  AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wr_val.intr && !trap && !(ctrl_q.pend && !out_full)) |=> !ctrl_q.intr); // R9
endmodule

// File: rtl/kbd_capture_reg.sv
module kbd_capture_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              trap,
  input  logic              trap_cmd,
  input  logic [DATA_W-1:0] io_byte,
  output logic [DATA_W-1:0] data_q,
  output logic              cmd_q
);
  logic [DATA_W-1:0] data_d;
  logic              data_ce;

  always_comb begin
    data_ce = trap || wr_data;
    data_d  = trap ? io_byte : wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cmd_q  <= 1'b0;
    end else begin
      if (data_ce) data_q <= data_d;
      if (trap)    cmd_q  <= trap_cmd;
    end
  end

  AST_TRAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> (data_q == $past(io_byte))); // R4
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap && !wr_data) |=> $stable(data_q)); // R7
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !trap |=> $stable(cmd_q)); // R6
endmodule

// File: rtl/kbd_emu_trap.sv
module kbd_emu_trap
  import kbd_emu_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CTRL_OFS  = 12'h100,
  parameter logic [ADDR_W-1:0] DATA_OFS  = 12'h104,
  parameter logic [PORT_W-1:0] PORT_DATA = 16'h0060,
  parameter logic [PORT_W-1:0] PORT_CMD  = 16'h0064
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              io_wr,
  input  logic [PORT_W-1:0] io_port,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              out_full,
  output logic              irq,
  output logic              cmd_port
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic              rst_n_s;
  logic              wr_ctrl;
  logic              wr_data;
  ctrl_t             wr_val;
  ctrl_t             ctrl_q;
  logic              trap;
  logic              trap_cmd;
  logic [DATA_W-1:0] data_q;

  kbd_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  always_comb begin
    wr_ctrl     = bus_sel && bus_wr && (bus_addr == CTRL_OFS);
    wr_data     = bus_sel && bus_wr && (bus_addr == DATA_OFS);
    wr_val.en   = bus_wdata[CTRL_EN_BIT];
    wr_val.intr = bus_wdata[CTRL_INTR_BIT];
    wr_val.pend = bus_wdata[CTRL_PEND_BIT];
  end

  kbd_io_decode #(
    .PORT_W    (PORT_W),
    .PORT_DATA (PORT_DATA),
    .PORT_CMD  (PORT_CMD)
  ) i_decode (
    .io_wr    (io_wr),
    .io_port  (io_port),
    .emu_en   (ctrl_q.en),
    .trap     (trap),
    .trap_cmd (trap_cmd)
  );

  kbd_ctrl_reg i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_ctrl  (wr_ctrl),
    .wr_val   (wr_val),
    .trap     (trap),
    .out_full (out_full),
    .ctrl_q   (ctrl_q),
    .irq      (irq)
  );

  kbd_capture_reg #(.DATA_W(DATA_W)) i_capture (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_data  (wr_data),
    .wr_byte  (bus_wdata[DATA_W-1:0]),
    .trap     (trap),
    .trap_cmd (trap_cmd),
    .io_byte  (io_wdata),
    .data_q   (data_q),
    .cmd_q    (cmd_port)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_OFS)      bus_rdata[CTRL_W-1:0] = ctrl_q;
    else if (bus_addr == DATA_OFS) bus_rdata[DATA_W-1:0] = data_q;
  end

  AST_NO_TRAP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ctrl_q.en |-> !trap); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq |-> (ctrl_q.en && ctrl_q.intr)); // R10
endmodule

// File: tb/test_kbd_emu_trap.sv
module test_kbd_emu_trap;
  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        io_wr;
  logic [15:0] io_port;
  logic [7:0]  io_wdata;
  logic        out_full;
  logic        irq;
  logic        cmd_port;

  int total;
  int bad;
  int m_en, m_intr, m_pend, m_data, m_cmd, m_irq;
  int unsigned seed;

  kbd_emu_trap i_kbd_emu_trap (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .io_wr(io_wr), .io_port(io_port), .io_wdata(io_wdata),
    .out_full(out_full), .irq(irq), .cmd_port(cmd_port)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural reference, updated at every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_intr = 0; m_pend = 0; m_data = 0; m_cmd = 0; m_irq = 0;
    end else begin
      int hit, setc, wc, wd;
      hit  = (io_wr && m_en != 0 && (io_port == 16'h60 || io_port == 16'h64)) ? 1 : 0;
      setc = (hit != 0 || (m_pend != 0 && !out_full)) ? 1 : 0;
      wc   = (bus_sel && bus_wr && bus_addr == 12'h100) ? 1 : 0;
      wd   = (bus_sel && bus_wr && bus_addr == 12'h104) ? 1 : 0;
      if (wc != 0) begin
        m_en = int'(bus_wdata[0]); m_intr = int'(bus_wdata[1]); m_pend = int'(bus_wdata[2]);
      end
      if (setc != 0) m_intr = 1;
      if (hit != 0) begin
        m_data = int'(io_wdata);
        m_cmd  = (io_port == 16'h64) ? 1 : 0;
      end else if (wd != 0) m_data = int'(bus_wdata[7:0]);
      m_irq = (m_intr != 0 && m_en != 0) ? 1 : 0;
    end
  end

  function automatic int exp_rd(input logic [11:0] a);
    if (a == 12'h100) return m_pend * 4 + m_intr * 2 + m_en;
    if (a == 12'h104) return m_data;
    return 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R10 irq", int'(irq), m_irq);
    chk("R6 cmd_port", int'(cmd_port), m_cmd);
    chk(bus_addr == 12'h104 ? "R3 rdata" : "R2 rdata", int'(bus_rdata), exp_rd(bus_addr));
  endtask

  task automatic cyc();
    @(negedge clk);
    cmp_all();
  endtask

  task automatic idle();
    bus_sel = 0; bus_wr = 0; io_wr = 0;
  endtask

  task automatic bw(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    cyc(); idle();
  endtask

  task automatic iow(input logic [15:0] p, input logic [7:0] d);
    io_wr = 1; io_port = p; io_wdata = d;
    cyc(); idle();
  endtask

  function automatic int rd(input logic [11:0] a);
    bus_addr = a;
    return 0;
  endfunction

  task automatic rchk(input string tag, input logic [11:0] a, input int exp);
    bus_addr = a;
    #0.5;
    chk(tag, int'(bus_rdata), exp);
  endtask

  function automatic int unsigned rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0; seed = 32'h1234_5678;
    rst_n = 0; idle(); bus_addr = 12'h100; bus_wdata = 0;
    io_port = 0; io_wdata = 0; out_full = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) cyc();
    // R1 reset state
    rchk("R1 ctrl", 12'h100, 0);
    rchk("R1 data", 12'h104, 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 cmd", int'(cmd_port), 0);
    // R2 enable, stray bits ignored
    bw(12'h100, 32'hFFFF_FFF9);
    rchk("R2 ctrl", 12'h100, 1);
    rchk("R3 unmapped", 12'h0FC, 0);
    chk("R10 no irq", int'(irq), 0);
    // R4/R5/R6 data port trap
    iow(16'h60, 8'hA5);
    rchk("R4 byte", 12'h104, 8'hA5);
    rchk("R5 intr", 12'h100, 3);
    chk("R10 irq", int'(irq), 1);
    chk("R6 data port", int'(cmd_port), 0);
    // R9 clear
    bw(12'h100, 32'h1);
    rchk("R9 cleared", 12'h100, 1);
    chk("R9 irq low", int'(irq), 0);
    // R6 command port
    iow(16'h64, 8'h3C);
    rchk("R4 cmd byte", 12'h104, 8'h3C);
    chk("R6 cmd port", int'(cmd_port), 1);
    bw(12'h100, 32'h1);
    // R3 direct write has no side effect
    bw(12'h104, 32'hFFFF_FF5A);
    rchk("R3 byte", 12'h104, 8'h5A);
    rchk("R3 ctrl same", 12'h100, 1);
    chk("R3 cmd same", int'(cmd_port), 1);
    // R7 wrong port
    iow(16'h61, 8'h77);
    rchk("R7 port byte", 12'h104, 8'h5A);
    rchk("R7 port intr", 12'h100, 1);
    // R7 disabled
    bw(12'h100, 32'h0);
    iow(16'h60, 8'h11);
    rchk("R7 off byte", 12'h104, 8'h5A);
    rchk("R7 off intr", 12'h100, 0);
    chk("R7 off cmd", int'(cmd_port), 1);
    // R8 pending character
    bw(12'h100, 32'h5);
    cyc();
    rchk("R8 wait", 12'h100, 5);
    chk("R8 no irq", int'(irq), 0);
    out_full = 0; cyc(); out_full = 1;
    rchk("R8 fired", 12'h100, 7);
    chk("R8 irq", int'(irq), 1);
    // R10 mask by enable
    bw(12'h100, 32'h2);
    rchk("R10 ctrl", 12'h100, 2);
    chk("R10 masked", int'(irq), 0);
    // R11 trap beats bus write
    bw(12'h100, 32'h1);
    io_wr = 1; io_port = 16'h60; io_wdata = 8'hC3;
    bus_sel = 1; bus_wr = 1; bus_addr = 12'h104; bus_wdata = 32'h44;
    cyc(); idle();
    rchk("R11 byte", 12'h104, 8'hC3);
    // R9 set wins over clear
    io_wr = 1; io_port = 16'h64; io_wdata = 8'h9E;
    bus_sel = 1; bus_wr = 1; bus_addr = 12'h100; bus_wdata = 32'h1;
    cyc(); idle();
    rchk("R9 set wins", 12'h100, 3);
    chk("R9 irq", int'(irq), 1);
    // mixed traffic against the reference
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = rnd();
      io_wr    = r[0];
      io_port  = (r[2:1] == 0) ? 16'h60 : (r[2:1] == 1) ? 16'h64 : (r[2:1] == 2) ? 16'h61 : 16'h0;
      io_wdata = r[15:8];
      out_full = r[16] | r[17];
      bus_sel  = r[18] & r[19];
      bus_wr   = r[20];
      bus_addr = (r[22:21] == 0) ? 12'h100 : (r[22:21] == 3) ? 12'h108 : 12'h104;
      bus_wdata = {rnd() & 32'hFFFF_FFF8, r[25] | r[26], r[27], r[28] | r[29]};
      cyc();
    end
    idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule